// File: doc/BRIEF.md
# Synchronous FIFO-Bus Read Controller

This block pulls data words out of an external FIFO bridge that shares the core clock and talks over an active-low handshake. The bridge holds a flag low while it has data. The controller answers by pulling an output-enable line and a read strobe low. On every rising edge where the strobe is low and the flag is low, the bridge hands over one word on the parallel data bus. Each captured word is passed on to an internal consumer as a one-cycle valid pulse.

The controller is a Moore machine. It samples the flag, the bus and the consumer's ready line on rising edges only. Both strobes are driven straight from flip-flops, so they change only just after a rising edge and carry no decode glitches. The consumer's ready line is sampled before the read strobe goes low. A word is therefore never drawn from the bridge unless the consumer had room at the edge that lowered the strobe. When a burst ends, the read strobe is released one cycle before the output-enable, so the bridge stops advancing before the bus is handed back.

Top module: `fifo_bus_reader`

## Requirements
- R1: A synchronous active-high `rst` forces `oeN` and `rdN` high and `outValid` low on the next rising edge, and leaves the machine idle.
- R2: While idle, both strobes go low on the edge that samples `rxAvailN` low together with `outReady` high. Otherwise both strobes stay high.
- R3: `rdN` is never low while `oeN` is high.
- R4: A word is captured on exactly those rising edges where `rdN` was low in the preceding cycle and `rxAvailN` is sampled low. `outValid` is high for the one cycle that follows such an edge and is low otherwise.
- R5: Once strobing, `rdN` stays low across every edge that samples `rxAvailN` low and `outReady` high.
- R6: An edge that samples `rxAvailN` high or `outReady` low while strobing raises `rdN`. `oeN` stays low for exactly one more cycle and then rises. The machine then sits idle with both strobes high for at least one cycle.
- R7: `rdN` falls only on an edge at which `outReady` was sampled high.
- R8: `outData` equals the value `busData` had at the capturing edge. Values on `busData` at edges where `rdN` was high produce no valid pulse.
- R9: Every word the bridge releases (strobe low and flag low at an edge) appears on the stream once, in bridge order, with no word lost or repeated outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core and bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rxAvailN | input | 1 | Bridge has data, active low |
| busData | input | DATA_W | Parallel data bus from the bridge |
| oeN | output | 1 | Bus output-enable to the bridge, active low, registered |
| rdN | output | 1 | Read strobe to the bridge, active low, registered |
| outData | output | DATA_W | Captured word toward the consumer |
| outValid | output | 1 | One-cycle pulse marking a captured word |
| outReady | input | 1 | Consumer can take words |

## Verification
The hardest case to reach is a burst that ends on the same edge in which a final word is still being captured. This happens when the consumer drops ready while the flag is low, or when the flag rises right after the strobe was committed. In both cases one word must still arrive, and the output-enable must lag the read strobe by exactly one cycle. The random stimulus drives ready low often and opens short gaps in the flag while the bridge model still holds words. It also refills the bridge in small lumps, so bursts of every length end in both ways. A directed reset in the middle of the run lands inside a burst, and the ordering check accounts for any word the bridge releases on that edge.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  // Controller states; strobing happens in stPrep and stRead.
  typedef enum logic [1:0] {
    stWait = 2'd0,
    stPrep = 2'd1,
    stRead = 2'd2,
    stDrop = 2'd3
  } rdState_t;

  // Strobes from control to datapath, evaluated for the coming edge.
  typedef struct packed {
    logic capture;   // take busData at this edge
    logic rdAssert;  // read strobe low after this edge
    logic oeAssert;  // output-enable low after this edge
  } rdStrobes_t;

endpackage

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
  import fbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rxAvailN,
  input  logic       outReady,
  output rdStrobes_t strobes
);

  rdState_t curState;
  rdState_t nextState;
  logic     strobing;
  logic     keepGoing;

  // Read strobe is low exactly while in the two strobing states.
  assign strobing  = (curState == stPrep) || (curState == stRead);
  assign keepGoing = !rxAvailN && outReady;

  always_comb begin
    nextState = curState;
    case (curState)
      stWait:  nextState = keepGoing ? stPrep : stWait;
      stPrep:  nextState = keepGoing ? stRead : stDrop;
      stRead:  nextState = keepGoing ? stRead : stDrop;
      stDrop:  nextState = stWait;
      default: nextState = stWait;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= stWait;
    else     curState <= nextState;
  end

  // Strobe levels are decoded from the next state and registered
  // downstream, so the pins equal a function of the state register.
  always_comb begin
    strobes.capture  = strobing && !rxAvailN;
    strobes.rdAssert = (nextState == stPrep) || (nextState == stRead);
    strobes.oeAssert = (nextState != stWait);
  end

endmodule

// File: rtl/fbr_datapath.sv
module fbr_datapath
  import fbr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  rdStrobes_t        strobes,
  input  logic [DATA_W-1:0] busData,
  output logic              oeN,
  output logic              rdN,
  output logic [DATA_W-1:0] outData,
  output logic              outValid
);

  // Pin flops: active-low strobes, reset high.
  always_ff @(posedge clk) begin
    if (rst) begin
      oeN <= 1'b1;
      rdN <= 1'b1;
    end else begin
      oeN <= !strobes.oeAssert;
      rdN <= !strobes.rdAssert;
    end
  end

  // Capture register and one-cycle valid pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strobes.capture;
      if (strobes.capture) outData <= busData;
    end
  end

endmodule

// File: rtl/fifo_bus_reader.sv
module fifo_bus_reader #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxAvailN,
  input  logic [DATA_W-1:0] busData,
  output logic              oeN,
  output logic              rdN,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady
);

  fbr_pkg::rdStrobes_t strobes;

  fbr_ctrl ctrl (
    .clk      (clk),
    .rst      (rst),
    .rxAvailN (rxAvailN),
    .outReady (outReady),
    .strobes  (strobes)
  );

  fbr_datapath #(.DATA_W(DATA_W)) dpath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .busData  (busData),
    .oeN      (oeN),
    .rdN      (rdN),
    .outData  (outData),
    .outValid (outValid)
  );

endmodule

// File: rtl/fifo_bus_reader_chk.sv
module fifo_bus_reader_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rxAvailN,
  input logic [DATA_W-1:0] busData,
  input logic              oeN,
  input logic              rdN,
  input logic [DATA_W-1:0] outData,
  input logic              outValid,
  input logic              outReady
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (oeN && rdN && !outValid));

  // R3
  rd_implies_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !rdN |-> !oeN);

  // R6
  oe_lags_rd_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rdN) && !$past(rst)) |-> !oeN);

  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rdN) && !$past(rst)) |=> oeN);

  // R4
  valid_source_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(!rdN && !rxAvailN));

  // R8
  data_match_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outData == $past(busData)));

  // R7
  strobe_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rdN) |-> $past(outReady));

endmodule

bind fifo_bus_reader fifo_bus_reader_chk #(.DATA_W(DATA_W)) chkInst (
  .clk      (clk),
  .rst      (rst),
  .rxAvailN (rxAvailN),
  .busData  (busData),
  .oeN      (oeN),
  .rdN      (rdN),
  .outData  (outData),
  .outValid (outValid),
  .outReady (outReady)
);

// File: tb/fifo_bus_reader_test.sv
`timescale 1ns/1ps
module fifo_bus_reader_test;

  localparam int DW     = 16;
  localparam int NCYC   = 6000;
  localparam int RSTCYC = 2500;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rxAvailN = 1'b1;
  logic [DW-1:0] busData = '0;
  logic          outReady = 1'b0;
  logic          oeN, rdN, outValid;
  logic [DW-1:0] outData;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  fifo_bus_reader #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .rxAvailN(rxAvailN), .busData(busData),
    .oeN(oeN), .rdN(rdN), .outData(outData), .outValid(outValid),
    .outReady(outReady)
  );

  // Bench state encoding: 0 idle, 1 prep, 2 read, 3 drop.
  function automatic int nextOf(int s, bit availLow, bit rdy);
    bit go = availLow && rdy;
    case (s)
      0: return go ? 1 : 0;
      1, 2: return go ? 2 : 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [DW-1:0] wordOf(int idx);
    int unsigned t = idx * 40503 + 32'h1d3;
    return t[DW-1:0] ^ DW'(idx);
  endfunction

  task automatic chk(string tag, longint got, longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int  expSt = 0;
    bit  expRdN = 1, expOeN = 1, expValid = 0;
    logic [DW-1:0] expData = '0;
    string strTag = "R1";
    string validTag = "R4";
    int  headIdx = 0, fill = 0, nextRecv = 0;
    bit  pendConsume = 0, lastReady = 0, prevRdN = 1;

    seed = $urandom(32'd2024);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 oeN after reset", oeN, 1);
    chk("R1 rdN after reset", rdN, 1);
    chk("R1 outValid after reset", outValid, 0);
    prevRdN = rdN;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      bit availLow, gap, rdy, doRst, strobing;
      int nxt, mode;
      @(negedge clk);
      // Compare against prediction made one cycle earlier.
      chk({strTag, " rdN"}, rdN, expRdN);
      chk({strTag, " oeN"}, oeN, expOeN);
      chk({validTag, " outValid"}, outValid, expValid);
      if (!rdN) chk("R3 rdN low needs oeN low", oeN, 0);
      if (prevRdN && !rdN) chk("R7 ready before strobe", lastReady, 1);
      if (outValid && expValid) begin
        chk("R8 captured word", outData, expData);
        chk("R9 stream order", outData, wordOf(nextRecv));
        nextRecv++;
      end
      prevRdN = rdN;

      // Bridge model advances on the word released at last edge.
      if (pendConsume) begin headIdx++; fill--; end
      if (fill < 64 && ($urandom % 4) == 0) fill += $urandom % 9;
      if (fill > 64) fill = 64;

      // Stimulus: phases with different pressure, plus a directed reset.
      mode = (cyc / 1000) % 3;
      case (mode)
        0: begin gap = ($urandom % 6) == 0; rdy = 1'b1; end
        1: begin gap = ($urandom % 10) == 0; rdy = ($urandom % 10) < 7; end
        default: begin gap = ($urandom % 3) == 0; rdy = ($urandom % 2) == 0; end
      endcase
      doRst    = (cyc == RSTCYC) || (cyc == RSTCYC + 1);
      availLow = (fill > 0) && !gap;

      rst      = doRst;
      outReady = rdy;
      rxAvailN = !availLow;
      busData  = availLow ? wordOf(headIdx) : DW'($urandom);
      lastReady = rdy;

      // Predict outcome of the coming edge.
      strobing    = (expSt == 1) || (expSt == 2);
      pendConsume = (rdN === 1'b0) && availLow;
      if (doRst) begin
        nxt = 0; expValid = 0; strTag = "R1"; validTag = "R1";
        if (pendConsume) nextRecv++;
      end else begin
        nxt = nextOf(expSt, availLow, rdy);
        expValid = strobing && availLow;
        expData  = busData;
        validTag = strobing ? "R4" : "R8";
        if (expSt == 0)   strTag = "R2";
        else if (nxt == 2) strTag = "R5";
        else               strTag = "R6";
      end
      expSt  = nxt;
      expRdN = !((nxt == 1) || (nxt == 2));
      expOeN = (nxt == 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule